// File: doc/BRIEF.md
# ATM Cell Transmit Processor

This block builds the outbound ATM cell stream of a transmit line interface. It takes 53-octet cells from two byte-wide sources. The first source is a FIFO of user cells. The second is an insertion buffer of cells supplied locally. When neither source holds a complete cell, the block generates idle cells itself. A cell is emitted at one octet per clock cycle. Once a cell has started, it always runs to its last octet.

User cells pass through optional processing. The header error check octet (HEC) can be verified, and cells that fail can be discarded. A fresh HEC can be written over the fifth octet. A header filter can either drop matching cells or pass them while sending a copy to an extraction port. Two saturating counters record HEC errors and discarded cells.

A route select sends the whole stream to one of two downstream paths. The select is captured at each cell start, so a change never splits a cell between the paths. Before a user cell is emitted, its header is staged for five cycles and judged for one more. Inserted cells and idle cells stream out without that pause.

Top module: `atm_tx_proc`

## Requirements
- R1: While `rstN` is low, `pathAValid`, `pathBValid` and `extValid` are 0, and both counters read 0.
- R2: With no complete cell in either source, the block emits idle cells back to back. An idle cell is the octets 00 00 00 01, then HEC 0x52, then 48 octets of 0x6A. There is no idle cycle between consecutive idle cells.
- R3: The source of a cell is chosen only at a cell boundary. The order of preference is user FIFO first, then insertion buffer, then idle generation. The output valid stays high for all 53 octets of a cell, and `*Soc` marks its first octet.
- R4: With checking, insertion and filtering all disabled, user cells appear unchanged and in FIFO order, even if their HEC octet is wrong.
- R5: With `hecInsertEn` = 1, octet index 4 of each user cell is replaced by the CRC-8 of octets 0..3. The CRC uses generator x^8+x^2+x+1, zero preset and MSB-first order, and the result is XORed with 0x55.
- R6: With `hecCheckEn` = 1, each user cell whose octet 4 differs from the computed HEC adds one to `hecErrCount`. With `hecDropEn` = 0, such a cell is still sent.
- R7: With `hecCheckEn` = 1 and `hecDropEn` = 1, a cell whose HEC is wrong is not sent, and `dropCount` rises by one.
- R8: With `filterEn` = 1, a cell matches when `((hdr[31:4] ^ filterValue) & filterMask) == 0`, where `hdr` is octets 0..3 taken MSB first. With `filterCopy` = 0, matching cells are dropped and counted in `dropCount`. Non-matching cells pass.
- R9: With `filterEn` = 1 and `filterCopy` = 1, a matching cell is sent, and the same 53 octets appear on the extraction port. Non-matching cells produce no extraction output.
- R10: With `routeSel` = 0, cells go to path A. With `routeSel` = 1, they go to path B. The unselected path never shows valid, and both paths are never valid in the same cycle.
- R11: Both counters stop at 2^CNT_W-1 instead of wrapping, and each changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usrCellAvail | input | 1 | User FIFO holds at least one complete cell |
| usrData | input | 8 | Head octet of the user FIFO |
| usrRd | output | 1 | Pop one octet from the user FIFO |
| insCellAvail | input | 1 | Insertion buffer holds at least one complete cell |
| insData | input | 8 | Head octet of the insertion buffer |
| insRd | output | 1 | Pop one octet from the insertion buffer |
| hecCheckEn | input | 1 | Verify the HEC of user cells |
| hecDropEn | input | 1 | Discard user cells that fail the HEC check |
| hecInsertEn | input | 1 | Overwrite octet 4 with a computed HEC |
| filterEn | input | 1 | Enable the header filter |
| filterCopy | input | 1 | 0 = drop matches, 1 = pass and copy matches |
| filterValue | input | 28 | Compare value for header bits 31..4 |
| filterMask | input | 28 | Compare mask, a 1 bit is compared |
| routeSel | input | 1 | Downstream path select, captured at cell start |
| pathAData | output | 8 | Path A octet |
| pathAValid | output | 1 | Path A octet valid |
| pathASoc | output | 1 | Path A first octet of a cell |
| pathBData | output | 8 | Path B octet |
| pathBValid | output | 1 | Path B octet valid |
| pathBSoc | output | 1 | Path B first octet of a cell |
| extData | output | 8 | Extraction copy octet |
| extValid | output | 1 | Extraction copy valid |
| extSoc | output | 1 | Extraction copy first octet |
| hecErrCount | output | CNT_W | Saturating count of HEC errors |
| dropCount | output | CNT_W | Saturating count of discarded cells |

## Verification
A wrong controller state shows up as a valid gap or a misplaced `*Soc` inside a cell. It can also appear as `usrRd` and `insRd` both being high. Any of these is visible within one cell time of 53 cycles.

A wrong header-stage value or a wrong judge decision shows up when the next user cell leaves the block, about 60 cycles after that cell was queued. The cell may be missing or extra, its fifth octet may be wrong, or a counter may not step. A stale route register puts a whole cell on the wrong path during the first cell after `routeSel` changes.

// File: rtl/atm_tx_pkg.sv
package atm_tx_pkg;

  localparam int CELL_LEN = 53;
  localparam int HDR_LEN  = 5;
  localparam int IDX_W    = $clog2(CELL_LEN);
  localparam int FILT_W   = 28;
  localparam logic [7:0] HEC_COSET = 8'h55;
  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] IDLE_FILL = 8'h6A;
  localparam logic [31:0] IDLE_HDR = 32'h0000_0001;

  typedef enum logic [2:0] {
    ST_PICK, ST_HDR, ST_JUDGE, ST_USR, ST_DRAIN, ST_INS, ST_IDLE
  } txState_e;

  typedef struct packed {
    logic             hdrCapture;
    logic             emitHdr;
    logic             emitUsrPay;
    logic             emitIns;
    logic             emitIdle;
    logic             copyOn;
    logic             cellStart;
    logic             incHecErr;
    logic             incDrop;
    logic [IDX_W-1:0] octIdx;
  } strobe_t;

  function automatic logic [7:0] hecCalc(input logic [31:0] hdr);
    logic [7:0] crc;
    logic       fb;
    crc = '0;
    for (int i = 31; i >= 0; i--) begin
      fb  = crc[7] ^ hdr[i];
      crc = {crc[6:0], 1'b0};
      if (fb) crc = crc ^ HEC_POLY;
    end
    return crc ^ HEC_COSET;
  endfunction

endpackage

// File: rtl/atm_tx_satcnt.sv
module atm_tx_satcnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) count <= '0;
    else if (inc && count != CNT_MAX) count <= count + 1'b1;
  end
endmodule

// File: rtl/atm_tx_ctrl.sv
module atm_tx_ctrl
  import atm_tx_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    usrCellAvail,
  input  logic    insCellAvail,
  input  logic    hecCheckEn,
  input  logic    hecDropEn,
  input  logic    filterEn,
  input  logic    filterCopy,
  input  logic    hecBad,
  input  logic    filterHit,
  output logic    usrRd,
  output logic    insRd,
  output strobe_t strb
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_LEN - 1);
  localparam logic [IDX_W-1:0] HDR_LAST = IDX_W'(HDR_LEN - 1);
  localparam logic [IDX_W-1:0] PAY_IDX  = IDX_W'(HDR_LEN);

  txState_e         state, stateNext;
  logic [IDX_W-1:0] idx, idxNext;
  logic             copyReg, copyNext;
  logic             dropCell, copyCell;
  txState_e         pickNext;

  // decision on the staged header
  assign dropCell = (hecCheckEn & hecDropEn & hecBad) |
                    (filterEn & ~filterCopy & filterHit);
  assign copyCell = filterEn & filterCopy & filterHit & ~dropCell;

  // fixed preference, evaluated only at a boundary
  always_comb begin
    if (usrCellAvail)      pickNext = ST_HDR;
    else if (insCellAvail) pickNext = ST_INS;
    else                   pickNext = ST_IDLE;
  end

  always_comb begin
    stateNext = state;
    idxNext   = idx;
    copyNext  = copyReg;
    case (state)
      ST_PICK: begin
        stateNext = pickNext;
        idxNext   = '0;
      end
      ST_HDR: begin
        if (idx == HDR_LAST) begin
          stateNext = ST_JUDGE;
          idxNext   = '0;
        end else begin
          idxNext = idx + 1'b1;
        end
      end
      ST_JUDGE: begin
        copyNext  = copyCell;
        stateNext = dropCell ? ST_DRAIN : ST_USR;
        idxNext   = dropCell ? PAY_IDX : '0;
      end
      ST_USR, ST_DRAIN, ST_INS, ST_IDLE: begin
        if (idx == LAST_IDX) begin
          stateNext = pickNext;
          idxNext   = '0;
        end else begin
          idxNext = idx + 1'b1;
        end
      end
      default: begin
        stateNext = ST_PICK;
        idxNext   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_PICK;
      idx     <= '0;
      copyReg <= 1'b0;
    end else begin
      state   <= stateNext;
      idx     <= idxNext;
      copyReg <= copyNext;
    end
  end

  always_comb begin
    strb            = '0;
    strb.octIdx     = idx;
    strb.hdrCapture = (state == ST_HDR);
    strb.emitHdr    = (state == ST_USR) && (idx < PAY_IDX);
    strb.emitUsrPay = (state == ST_USR) && (idx >= PAY_IDX);
    strb.emitIns    = (state == ST_INS);
    strb.emitIdle   = (state == ST_IDLE);
    strb.copyOn     = copyReg && (state == ST_USR);
    strb.cellStart  = (state == ST_USR || state == ST_INS || state == ST_IDLE) &&
                      (idx == '0);
    strb.incHecErr  = (state == ST_JUDGE) && hecCheckEn && hecBad;
    strb.incDrop    = (state == ST_JUDGE) && dropCell;
  end

  assign usrRd = (state == ST_HDR) || (state == ST_DRAIN) ||
                 ((state == ST_USR) && (idx >= PAY_IDX));
  assign insRd = (state == ST_INS);

endmodule

// File: rtl/atm_tx_datapath.sv
module atm_tx_datapath
  import atm_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [7:0]        usrData,
  input  logic [7:0]        insData,
  input  logic              hecInsertEn,
  input  logic [FILT_W-1:0] filterValue,
  input  logic [FILT_W-1:0] filterMask,
  input  logic              routeSel,
  output logic              hecBad,
  output logic              filterHit,
  output logic [7:0]        pathAData,
  output logic              pathAValid,
  output logic              pathASoc,
  output logic [7:0]        pathBData,
  output logic              pathBValid,
  output logic              pathBSoc,
  output logic [7:0]        extData,
  output logic              extValid,
  output logic              extSoc,
  output logic [CNT_W-1:0]  hecErrCount,
  output logic [CNT_W-1:0]  dropCount
);
  localparam logic [7:0] IDLE_HEC = hecCalc(IDLE_HDR);

  logic [7:0]  hdrOct [HDR_LEN];
  logic [31:0] hdrWord;
  logic [7:0]  hecCalcd;
  logic [7:0]  curOct;
  logic        curValid;
  logic        routeReg, routeCur;
  logic        copyNow;

  // header staging, one register per octet
  for (genvar g = 0; g < HDR_LEN; g++) begin : gHdr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) hdrOct[g] <= '0;
      else if (strb.hdrCapture && strb.octIdx == IDX_W'(g)) hdrOct[g] <= usrData;
    end
  end

  assign hdrWord   = {hdrOct[0], hdrOct[1], hdrOct[2], hdrOct[3]};
  assign hecCalcd  = hecCalc(hdrWord);
  assign hecBad    = (hecCalcd != hdrOct[4]);
  assign filterHit = (((hdrWord[31:4] ^ filterValue) & filterMask) == '0);

  // octet source mux
  always_comb begin
    curOct = '0;
    if (strb.emitHdr) begin
      case (strb.octIdx)
        IDX_W'(0): curOct = hdrOct[0];
        IDX_W'(1): curOct = hdrOct[1];
        IDX_W'(2): curOct = hdrOct[2];
        IDX_W'(3): curOct = hdrOct[3];
        IDX_W'(4): curOct = hecInsertEn ? hecCalcd : hdrOct[4];
        default:   curOct = '0;
      endcase
    end else if (strb.emitUsrPay) begin
      curOct = usrData;
    end else if (strb.emitIns) begin
      curOct = insData;
    end else if (strb.emitIdle) begin
      if (strb.octIdx < IDX_W'(3))       curOct = 8'h00;
      else if (strb.octIdx == IDX_W'(3)) curOct = IDLE_HDR[7:0];
      else if (strb.octIdx == IDX_W'(4)) curOct = IDLE_HEC;
      else                               curOct = IDLE_FILL;
    end
  end

  assign curValid = strb.emitHdr | strb.emitUsrPay | strb.emitIns | strb.emitIdle;
  assign routeCur = strb.cellStart ? routeSel : routeReg;
  assign copyNow  = strb.copyOn & (strb.emitHdr | strb.emitUsrPay);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      routeReg   <= 1'b0;
      pathAData  <= '0;
      pathAValid <= 1'b0;
      pathASoc   <= 1'b0;
      pathBData  <= '0;
      pathBValid <= 1'b0;
      pathBSoc   <= 1'b0;
      extData    <= '0;
      extValid   <= 1'b0;
      extSoc     <= 1'b0;
    end else begin
      if (strb.cellStart) routeReg <= routeSel;
      pathAValid <= curValid & ~routeCur;
      pathASoc   <= strb.cellStart & ~routeCur;
      pathAData  <= (curValid & ~routeCur) ? curOct : '0;
      pathBValid <= curValid & routeCur;
      pathBSoc   <= strb.cellStart & routeCur;
      pathBData  <= (curValid & routeCur) ? curOct : '0;
      extValid   <= copyNow;
      extSoc     <= copyNow & strb.cellStart;
      extData    <= copyNow ? curOct : '0;
    end
  end

  atm_tx_satcnt #(.CNT_W(CNT_W)) uHecErrCnt (
    .clk(clk), .rstN(rstN), .inc(strb.incHecErr), .count(hecErrCount)
  );

  atm_tx_satcnt #(.CNT_W(CNT_W)) uDropCnt (
    .clk(clk), .rstN(rstN), .inc(strb.incDrop), .count(dropCount)
  );

endmodule

// File: rtl/atm_tx_proc.sv
module atm_tx_proc
  import atm_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usrCellAvail,
  input  logic [7:0]        usrData,
  output logic              usrRd,
  input  logic              insCellAvail,
  input  logic [7:0]        insData,
  output logic              insRd,
  input  logic              hecCheckEn,
  input  logic              hecDropEn,
  input  logic              hecInsertEn,
  input  logic              filterEn,
  input  logic              filterCopy,
  input  logic [FILT_W-1:0] filterValue,
  input  logic [FILT_W-1:0] filterMask,
  input  logic              routeSel,
  output logic [7:0]        pathAData,
  output logic              pathAValid,
  output logic              pathASoc,
  output logic [7:0]        pathBData,
  output logic              pathBValid,
  output logic              pathBSoc,
  output logic [7:0]        extData,
  output logic              extValid,
  output logic              extSoc,
  output logic [CNT_W-1:0]  hecErrCount,
  output logic [CNT_W-1:0]  dropCount
);
  strobe_t strb;
  logic    hecBad;
  logic    filterHit;

  atm_tx_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .usrCellAvail(usrCellAvail), .insCellAvail(insCellAvail),
    .hecCheckEn(hecCheckEn), .hecDropEn(hecDropEn),
    .filterEn(filterEn), .filterCopy(filterCopy),
    .hecBad(hecBad), .filterHit(filterHit),
    .usrRd(usrRd), .insRd(insRd), .strb(strb)
  );

  atm_tx_datapath #(.CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .usrData(usrData), .insData(insData),
    .hecInsertEn(hecInsertEn),
    .filterValue(filterValue), .filterMask(filterMask),
    .routeSel(routeSel),
    .hecBad(hecBad), .filterHit(filterHit),
    .pathAData(pathAData), .pathAValid(pathAValid), .pathASoc(pathASoc),
    .pathBData(pathBData), .pathBValid(pathBValid), .pathBSoc(pathBSoc),
    .extData(extData), .extValid(extValid), .extSoc(extSoc),
    .hecErrCount(hecErrCount), .dropCount(dropCount)
  );

endmodule

// File: rtl/atm_tx_proc_chk.sv
module atm_tx_proc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             pathAValid,
  input logic             pathBValid,
  input logic             pathASoc,
  input logic             pathBSoc,
  input logic             extValid,
  input logic             usrRd,
  input logic             insRd,
  input logic [CNT_W-1:0] hecErrCount,
  input logic [CNT_W-1:0] dropCount
);
  localparam int CELL_OCTS = 53;
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic       anyValid, anySoc;
  logic [5:0] octCnt;

  assign anyValid = pathAValid | pathBValid;
  assign anySoc   = pathASoc | pathBSoc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) octCnt <= '0;
    else if (anyValid) octCnt <= (octCnt == 6'(CELL_OCTS - 1)) ? '0 : octCnt + 1'b1;
  end

  AST_PATH_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(pathAValid && pathBValid)); // R10
  AST_SOC_ALIGN: assert property (@(posedge clk) disable iff (!rstN)
    anyValid |-> (anySoc == (octCnt == '0))); // R3
  AST_NO_MID_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (octCnt != '0) |-> anyValid); // R3
  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    !(usrRd && insRd)); // R3
  AST_EXT_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    extValid |-> anyValid); // R9
  AST_ERR_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (hecErrCount == CNT_TOP) |=> (hecErrCount == CNT_TOP)); // R11
  AST_DROP_SAT: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount == CNT_TOP) |=> (dropCount == CNT_TOP)); // R11
  AST_DROP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (dropCount != $past(dropCount)) |-> (dropCount == $past(dropCount) + 1'b1)); // R11
  AST_ERR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (hecErrCount != $past(hecErrCount)) |-> (hecErrCount == $past(hecErrCount) + 1'b1)); // R11

endmodule

bind atm_tx_proc atm_tx_proc_chk #(.CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN),
  .pathAValid(pathAValid), .pathBValid(pathBValid),
  .pathASoc(pathASoc), .pathBSoc(pathBSoc),
  .extValid(extValid), .usrRd(usrRd), .insRd(insRd),
  .hecErrCount(hecErrCount), .dropCount(dropCount)
);

// File: tb/atm_tx_proc_test.sv
module atm_tx_proc_test;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usrCellAvail = 1'b0;
  logic [7:0] usrData = '0;
  logic usrRd;
  logic insCellAvail = 1'b0;
  logic [7:0] insData = '0;
  logic insRd;
  logic hecCheckEn = 0, hecDropEn = 0, hecInsertEn = 0;
  logic filterEn = 0, filterCopy = 0, routeSel = 0;
  logic [27:0] filterValue = '0, filterMask = '0;
  logic [7:0] pathAData, pathBData, extData;
  logic pathAValid, pathASoc, pathBValid, pathBSoc, extValid, extSoc;
  logic [CNT_W-1:0] hecErrCount, dropCount;

  always #5 clk = ~clk;

  atm_tx_proc #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN),
    .usrCellAvail(usrCellAvail), .usrData(usrData), .usrRd(usrRd),
    .insCellAvail(insCellAvail), .insData(insData), .insRd(insRd),
    .hecCheckEn(hecCheckEn), .hecDropEn(hecDropEn), .hecInsertEn(hecInsertEn),
    .filterEn(filterEn), .filterCopy(filterCopy),
    .filterValue(filterValue), .filterMask(filterMask), .routeSel(routeSel),
    .pathAData(pathAData), .pathAValid(pathAValid), .pathASoc(pathASoc),
    .pathBData(pathBData), .pathBValid(pathBValid), .pathBSoc(pathBSoc),
    .extData(extData), .extValid(extValid), .extSoc(extSoc),
    .hecErrCount(hecErrCount), .dropCount(dropCount)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  logic [7:0] usrQ[$];
  logic [7:0] insQ[$];
  logic usrPop = 0, insPop = 0;

  logic [423:0] cellsA[$];
  logic [423:0] cellsB[$];
  logic [423:0] cellsE[$];
  logic [423:0] shA = '0, shB = '0, shE = '0;
  int nA = 0, nB = 0, nE = 0;
  bit trackGaps = 0, sawValid = 0;
  int gapCnt = 0;
  int expErr = 0, expDrop = 0;

  function automatic logic [7:0] refHec(input logic [31:0] h);
    logic [7:0] r;
    r = 8'h00;
    for (int b = 31; b >= 0; b--) begin
      if (r[7] ^ h[b]) r = (r << 1) ^ 8'h07;
      else r = r << 1;
    end
    return r ^ 8'h55;
  endfunction

  function automatic logic [423:0] mkCell(input logic [31:0] h, input logic [7:0] hec,
                                          input logic [7:0] seed);
    logic [423:0] c;
    c[423:384] = {h, hec};
    for (int i = 0; i < 48; i++) c[383 - 8*i -: 8] = seed + 8'(i);
    return c;
  endfunction

  function automatic logic [423:0] idleCell();
    logic [423:0] c;
    c[423:384] = {32'h0000_0001, 8'h52};
    for (int i = 0; i < 48; i++) c[383 - 8*i -: 8] = 8'h6A;
    return c;
  endfunction

  function automatic bit isIdle(input logic [423:0] c);
    return c[423:392] == 32'h0000_0001;
  endfunction

  task automatic refreshInputs();
    usrData      = (usrQ.size() > 0) ? usrQ[0] : 8'h00;
    usrCellAvail = (usrQ.size() >= 53);
    insData      = (insQ.size() > 0) ? insQ[0] : 8'h00;
    insCellAvail = (insQ.size() >= 53);
  endtask

  always @(posedge clk) begin
    usrPop <= usrRd;
    insPop <= insRd;
  end

  always @(negedge clk) begin
    if (usrPop && usrQ.size() > 0) void'(usrQ.pop_front());
    if (insPop && insQ.size() > 0) void'(insQ.pop_front());
    refreshInputs();
    if (pathAValid) begin
      if (pathASoc) nA = 0;
      shA = {shA[415:0], pathAData}; nA++;
      if (nA == 53) begin cellsA.push_back(shA); nA = 0; end
    end
    if (pathBValid) begin
      if (pathBSoc) nB = 0;
      shB = {shB[415:0], pathBData}; nB++;
      if (nB == 53) begin cellsB.push_back(shB); nB = 0; end
    end
    if (extValid) begin
      if (extSoc) nE = 0;
      shE = {shE[415:0], extData}; nE++;
      if (nE == 53) begin cellsE.push_back(shE); nE = 0; end
    end
    if (trackGaps) begin
      if (pathAValid || pathBValid) sawValid = 1;
      else if (sawValid) gapCnt++;
    end
  end

  task automatic check(input bit ok, input string req, input logic [423:0] act,
                       input logic [423:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pushUsr(input logic [423:0] c);
    for (int i = 0; i < 53; i++) usrQ.push_back(c[423 - 8*i -: 8]);
    refreshInputs();
  endtask

  task automatic pushIns(input logic [423:0] c);
    for (int i = 0; i < 53; i++) insQ.push_back(c[423 - 8*i -: 8]);
    refreshInputs();
  endtask

  task automatic clearCaps();
    cellsA.delete(); cellsB.delete(); cellsE.delete();
  endtask

  task automatic drain();
    int t;
    t = 0;
    while ((usrQ.size() != 0 || insQ.size() != 0) && t < 30000) begin
      @(negedge clk); t++;
    end
    if (t >= 30000) check(0, "watchdog drain", 424'(usrQ.size()), 424'(0));
    repeat (70) @(negedge clk);
  endtask

  function automatic int userCount(input int path);
    int n;
    n = 0;
    if (path == 0) begin foreach (cellsA[i]) if (!isIdle(cellsA[i])) n++; end
    else begin foreach (cellsB[i]) if (!isIdle(cellsB[i])) n++; end
    return n;
  endfunction

  function automatic logic [423:0] userCell(input int k);
    int n;
    n = 0;
    foreach (cellsA[i]) begin
      if (!isIdle(cellsA[i])) begin
        if (n == k) return cellsA[i];
        n++;
      end
    end
    return '0;
  endfunction

  task automatic checkCounters(input string req);
    check(hecErrCount == CNT_W'(expErr), {req, " hecErrCount"}, 424'(hecErrCount), 424'(expErr));
    check(dropCount == CNT_W'(expDrop), {req, " dropCount"}, 424'(dropCount), 424'(expDrop));
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check(!pathAValid && !pathBValid && !extValid, "R1 valids",
          424'({pathAValid, pathBValid, extValid}), 424'(0));
    checkCounters("R1");
    rstN = 1'b1;
  endtask

  task automatic testIdle();
    trackGaps = 1; sawValid = 0; gapCnt = 0;
    clearCaps();
    repeat (250) @(negedge clk);
    trackGaps = 0;
    check(cellsA.size() >= 3, "R2 idle count", 424'(cellsA.size()), 424'(3));
    foreach (cellsA[i]) check(cellsA[i] == idleCell(), "R2 idle format", cellsA[i], idleCell());
    check(gapCnt == 0, "R2 back-to-back", 424'(gapCnt), 424'(0));
    check(refHec(32'h1) == 8'h52, "R5 hec of idle header", 424'(refHec(32'h1)), 424'(8'h52));
  endtask

  task automatic testPass();
    logic [423:0] c[3];
    c[0] = mkCell(32'h0123_4560, 8'hAA, 8'h10);
    c[1] = mkCell(32'h0222_2220, 8'h00, 8'h40);
    c[2] = mkCell(32'h0F0F_0F00, 8'h5C, 8'h90);
    clearCaps();
    @(negedge clk);
    for (int i = 0; i < 3; i++) pushUsr(c[i]);
    drain();
    check(userCount(0) == 3, "R4 cell count", 424'(userCount(0)), 424'(3));
    for (int i = 0; i < 3; i++) check(userCell(i) == c[i], "R4 unchanged", userCell(i), c[i]);
  endtask

  task automatic testInsert();
    logic [423:0] c, e;
    hecInsertEn = 1;
    c = mkCell(32'h0345_6780, 8'h11, 8'h21);
    e = mkCell(32'h0345_6780, refHec(32'h0345_6780), 8'h21);
    clearCaps();
    @(negedge clk);
    pushUsr(c);
    drain();
    check(userCount(0) == 1, "R5 count", 424'(userCount(0)), 424'(1));
    check(userCell(0) == e, "R5 hec written", userCell(0), e);
    hecInsertEn = 0;
  endtask

  task automatic testCheckNoDrop();
    logic [423:0] g, b;
    hecCheckEn = 1; hecDropEn = 0;
    g = mkCell(32'h0444_4440, refHec(32'h0444_4440), 8'h31);
    b = mkCell(32'h0555_5550, ~refHec(32'h0555_5550), 8'h32);
    clearCaps();
    @(negedge clk);
    pushUsr(g); pushUsr(b);
    drain();
    expErr++;
    check(userCount(0) == 2, "R6 bad still sent", 424'(userCount(0)), 424'(2));
    check(userCell(1) == b, "R6 bad cell content", userCell(1), b);
    checkCounters("R6");
  endtask

  task automatic testCheckDrop();
    logic [423:0] g, b;
    hecCheckEn = 1; hecDropEn = 1;
    b = mkCell(32'h0666_6660, refHec(32'h0666_6660) ^ 8'h01, 8'h41);
    g = mkCell(32'h0777_7770, refHec(32'h0777_7770), 8'h42);
    clearCaps();
    @(negedge clk);
    pushUsr(b); pushUsr(g);
    drain();
    expErr++; expDrop++;
    check(userCount(0) == 1, "R7 bad dropped", 424'(userCount(0)), 424'(1));
    check(userCell(0) == g, "R7 good kept", userCell(0), g);
    checkCounters("R7");
    hecCheckEn = 0; hecDropEn = 0;
  endtask

  task automatic testFilterDrop();
    logic [423:0] x, y, z;
    filterEn = 1; filterCopy = 0;
    filterValue = 28'h0ABCDE2; filterMask = 28'hFFFFFFF;
    x = mkCell(32'h0ABC_DE20, 8'h00, 8'h51);
    y = mkCell(32'h0ABC_DF20, 8'h00, 8'h52);
    clearCaps();
    @(negedge clk);
    pushUsr(x); pushUsr(y);
    drain();
    expDrop++;
    check(userCount(0) == 1, "R8 match dropped", 424'(userCount(0)), 424'(1));
    check(userCell(0) == y, "R8 miss passes", userCell(0), y);
    checkCounters("R8");
    filterMask = 28'hFFFFF00;
    z = mkCell(32'h0ABC_DEF0, 8'h00, 8'h53);
    clearCaps();
    @(negedge clk);
    pushUsr(z);
    drain();
    expDrop++;
    check(userCount(0) == 0, "R8 masked match dropped", 424'(userCount(0)), 424'(0));
    checkCounters("R8 mask");
    filterEn = 0;
  endtask

  task automatic testFilterCopy();
    logic [423:0] x, y;
    filterEn = 1; filterCopy = 1;
    filterValue = 28'h0ABCDE2; filterMask = 28'hFFFFFFF;
    x = mkCell(32'h0ABC_DE20, 8'h77, 8'h61);
    y = mkCell(32'h0123_0000, 8'h66, 8'h62);
    clearCaps();
    @(negedge clk);
    pushUsr(x); pushUsr(y);
    drain();
    check(userCount(0) == 2, "R9 both sent", 424'(userCount(0)), 424'(2));
    check(cellsE.size() == 1, "R9 one copy", 424'(cellsE.size()), 424'(1));
    if (cellsE.size() > 0) check(cellsE[0] == x, "R9 copy content", cellsE[0], x);
    checkCounters("R9");
    filterEn = 0; filterCopy = 0;
  endtask

  task automatic testPriority();
    logic [423:0] u, ic;
    u  = mkCell(32'h0888_8880, 8'h01, 8'h71);
    ic = mkCell(32'h0999_9990, 8'h02, 8'h72);
    clearCaps();
    @(negedge clk);
    pushIns(ic); pushUsr(u);
    drain();
    check(userCount(0) == 2, "R3 both sent", 424'(userCount(0)), 424'(2));
    check(userCell(0) == u, "R3 user first", userCell(0), u);
    check(userCell(1) == ic, "R3 insert second", userCell(1), ic);
    clearCaps();
    @(negedge clk);
    pushIns(ic);
    drain();
    check(userCount(0) == 1 && userCell(0) == ic, "R3 insert alone", userCell(0), ic);
  endtask

  task automatic testRoute();
    logic [423:0] u;
    u = mkCell(32'h0AAA_AAA0, 8'h03, 8'h81);
    routeSel = 1;
    repeat (60) @(negedge clk);
    clearCaps();
    pushUsr(u);
    drain();
    check(userCount(1) == 1, "R10 on path B", 424'(userCount(1)), 424'(1));
    check(cellsA.size() == 0, "R10 path A silent", 424'(cellsA.size()), 424'(0));
    if (cellsB.size() > 0) check(cellsB[cellsB.size() - 1] != '0, "R10 B data", cellsB[0], u);
    routeSel = 0;
    repeat (60) @(negedge clk);
  endtask

  task automatic testSaturate();
    hecCheckEn = 1; hecDropEn = 1;
    @(negedge clk);
    for (int i = 0; i < 260; i++) pushUsr(mkCell(32'h0BBB_0000 + 32'(i << 4), 8'hFF ^ refHec(32'h0BBB_0000 + 32'(i << 4)), 8'(i)));
    drain();
    expErr = 255; expDrop = 255;
    checkCounters("R11 saturate");
    hecCheckEn = 0; hecDropEn = 0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    testReset();
    testIdle();
    testPass();
    testInsert();
    testCheckNoDrop();
    testCheckDrop();
    testFilterDrop();
    testFilterCopy();
    testPriority();
    testRoute();
    testSaturate();
    finish();
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

endmodule